// File: doc/BRIEF.md
# CSR State-Enable Access Gate

This block decides, for each control-and-status register access issued by a hart that supports a hypervisor and an advanced interrupt architecture, whether the access may proceed. Three interrupt-related enable bits live in the 64-bit machine and hypervisor state-enable registers (word 0). Every interrupt-related CSR address belongs to one of three groups, and each group is tied to one of those bits:

- the interrupt-file group, bit 58;
- the interrupt-architecture group, bit 59;
- the indirect-select group, bit 60.

When an access is refused, the block reports which trap the hart should take: an illegal-instruction trap or a virtual-instruction trap.

Alongside the verdict, the block produces three further results:

- the legal write masks for the state-enable registers, for the full 64-bit word and for the 32-bit upper half used on RV32;
- the effective guest interrupt file index, which is forced to zero when the hypervisor has withdrawn interrupt-file access;
- the legal write mask for the guest external interrupt enable register.

The request is presented with `req_valid`. Every result is registered and appears one clock later, with the verdict qualified by `resp_valid`. The CSR storage, the interrupt files and instruction decode sit outside this block.

Top module: `csr_stateen_gate`

## Requirements
- R1: The addresses 0x15C, 0x25C, 0x600, 0x607 and 0xE12 are gated by state-enable bit 58 (interrupt file).
- R2: The addresses 0x114, 0x154, 0x214, 0x254, 0x613, 0x609, 0x655, 0x646, 0x647, 0x656 and 0x657 are gated by state-enable bit 59 (interrupt architecture).
- R3: The addresses 0x150 and 0x250 are gated by state-enable bit 60 (indirect select).
- R4: Any other address is allowed. When `stateen_present` is 0, every access is allowed.
- R5: An access at machine privilege (`priv` = 2'b11) is always allowed. Privilege encodings are 2'b00 user, 2'b01 supervisor and 2'b11 machine.
- R6: Below machine privilege, a gated access whose bit is clear in `mstateen0` raises an illegal-instruction trap. This holds whatever the `hstateen0` bit and the virtualization flag are.
- R7: Below machine privilege with `virt_mode` set, a gated access whose `mstateen0` bit is set and whose `hstateen0` bit is clear raises a virtual-instruction trap. When both bits are set, the access is allowed.
- R8: The verdict appears one clock after the request. When `resp_valid` is 1, exactly one of `resp_allow`, `resp_illegal` and `resp_virtual` is 1. When `resp_valid` is 0, all three are 0.
- R9: When `intr_arch_present` is 1, `mstateen0_wmask` and `hstateen0_wmask` have exactly bits 58..60 set and `stateen0h_wmask` has exactly bits 26..28 set. Otherwise all three masks are zero.
- R10: `vgein_eff` equals `vgein` only when `virt_mode` is 1, `priv` is below machine, and either `stateen_present` is 0 or `hstateen0[58]` is 1. In every other case it is zero.
- R11: `hgeie_wmask` has exactly bits GEILEN down to 1 set, and bit 0 is never set.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| csr_addr | input | 12 | CSR address being accessed |
| priv | input | 2 | Current privilege level |
| virt_mode | input | 1 | Hart is running a guest |
| mstateen0 | input | 64 | Machine state-enable word 0 |
| hstateen0 | input | 64 | Hypervisor state-enable word 0 |
| stateen_present | input | 1 | State-enable extension implemented |
| intr_arch_present | input | 1 | Advanced interrupt architecture implemented |
| vgein | input | 6 | Guest external interrupt number from hstatus |
| resp_valid | output | 1 | Verdict is valid |
| resp_allow | output | 1 | Access allowed |
| resp_illegal | output | 1 | Raise illegal-instruction trap |
| resp_virtual | output | 1 | Raise virtual-instruction trap |
| mstateen0_wmask | output | 64 | Writable interrupt bits of mstateen0 |
| hstateen0_wmask | output | 64 | Writable interrupt bits of hstateen0 |
| stateen0h_wmask | output | 32 | Writable interrupt bits of the RV32 upper halves |
| vgein_eff | output | 6 | Effective guest interrupt file index |
| hgeie_wmask | output | 64 | Writable bits of the guest interrupt enable register |

## Verification
The hardest case to reach is the one where the two state-enable registers disagree under virtualization. The `mstateen0` bit must be set and the `hstateen0` bit clear, and this has to be shown separately from the case where both bits are clear, because in that case the illegal-instruction trap must win. The stimulus therefore sweeps every combination of the three machine bits and the three hypervisor bits against each privilege level and virtualization setting, for every gated address and several ungated ones. Unrelated bits of both registers carry a fixed non-zero pattern, so that a decode picking the wrong bit position shows up.

// File: rtl/stateen_gate_pkg.sv
package stateen_gate_pkg;

    // Positions of the interrupt enables in stateen word 0
    localparam int unsigned SE_BIT_IFILE = 58;
    localparam int unsigned SE_BIT_INTR  = 59;
    localparam int unsigned SE_BIT_ISEL  = 60;
    localparam int unsigned SE_HI_BASE   = 32;
    localparam int unsigned SE_NUM_BITS  = 3;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_IFILE = 2'd1,
        GRP_INTR  = 2'd2,
        GRP_ISEL  = 2'd3
    } gate_grp_e;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    typedef struct packed {
        logic allow;
        logic illegal;
        logic virt_trap;
    } verdict_t;

    // Interrupt-file group
    localparam logic [11:0] A_STOPEI   = 12'h15C;
    localparam logic [11:0] A_VSTOPEI  = 12'h25C;
    localparam logic [11:0] A_HSTATUS  = 12'h600;
    localparam logic [11:0] A_HGEIE    = 12'h607;
    localparam logic [11:0] A_HGEIP    = 12'hE12;
    // Interrupt-architecture group
    localparam logic [11:0] A_SIEH     = 12'h114;
    localparam logic [11:0] A_SIPH     = 12'h154;
    localparam logic [11:0] A_VSIEH    = 12'h214;
    localparam logic [11:0] A_VSIPH    = 12'h254;
    localparam logic [11:0] A_HIDELEGH = 12'h613;
    localparam logic [11:0] A_HVICTL   = 12'h609;
    localparam logic [11:0] A_HVIPH    = 12'h655;
    localparam logic [11:0] A_HVIPRIO1 = 12'h646;
    localparam logic [11:0] A_HVIPRIO2 = 12'h647;
    localparam logic [11:0] A_HVIPR1H  = 12'h656;
    localparam logic [11:0] A_HVIPR2H  = 12'h657;
    // Indirect-select group
    localparam logic [11:0] A_SISEL    = 12'h150;
    localparam logic [11:0] A_VSISEL   = 12'h250;

endpackage

// File: rtl/csr_group_decode.sv
module csr_group_decode
    import stateen_gate_pkg::*;
(
    input  logic [11:0] addr,
    output gate_grp_e   grp
);

    always_comb begin
        unique case (addr)
            A_STOPEI, A_VSTOPEI, A_HSTATUS, A_HGEIE, A_HGEIP:
                grp = GRP_IFILE;
            A_SIEH, A_SIPH, A_VSIEH, A_VSIPH, A_HIDELEGH, A_HVICTL,
            A_HVIPH, A_HVIPRIO1, A_HVIPRIO2, A_HVIPR1H, A_HVIPR2H:
                grp = GRP_INTR;
            A_SISEL, A_VSISEL:
                grp = GRP_ISEL;
            default:
                grp = GRP_NONE;
        endcase
    end

endmodule

// File: rtl/stateen_verdict.sv
module stateen_verdict
    import stateen_gate_pkg::*;
(
    input  gate_grp_e              grp,
    input  logic [1:0]             priv,
    input  logic                   virt_mode,
    input  logic                   stateen_present,
    input  logic [SE_NUM_BITS-1:0] m_bits,
    input  logic [SE_NUM_BITS-1:0] h_bits,
    output verdict_t               verdict
);

    logic m_sel;
    logic h_sel;

    always_comb begin
        unique case (grp)
            GRP_IFILE: begin m_sel = m_bits[0]; h_sel = h_bits[0]; end
            GRP_INTR:  begin m_sel = m_bits[1]; h_sel = h_bits[1]; end
            GRP_ISEL:  begin m_sel = m_bits[2]; h_sel = h_bits[2]; end
            default:   begin m_sel = 1'b1;      h_sel = 1'b1;      end
        endcase
    end

    always_comb begin
        verdict = '0;
        if (!stateen_present || grp == GRP_NONE || priv == PRIV_M) begin
            verdict.allow = 1'b1;
        end else if (!m_sel) begin
            verdict.illegal = 1'b1;
        end else if (virt_mode && !h_sel) begin
            verdict.virt_trap = 1'b1;
        end else begin
            verdict.allow = 1'b1;
        end
    end

endmodule

// File: rtl/stateen_mask_gen.sv
module stateen_mask_gen
    import stateen_gate_pkg::*;
#(
    parameter int unsigned SE_W = 64
) (
    input  logic              intr_present,
    output logic [SE_W-1:0]   full_mask,
    output logic [SE_W/2-1:0] hi_mask
);

    localparam int unsigned HALF_W = SE_W / 2;

    genvar gi;
    generate
        for (gi = 0; gi < SE_W; gi++) begin : g_full
            if (gi >= SE_BIT_IFILE && gi <= SE_BIT_ISEL) begin : g_on
                assign full_mask[gi] = intr_present;
            end else begin : g_off
                assign full_mask[gi] = 1'b0;
            end
        end
        for (gi = 0; gi < HALF_W; gi++) begin : g_hi
            assign hi_mask[gi] = full_mask[gi + HALF_W];
        end
    endgenerate

endmodule

// File: rtl/guest_file_select.sv
module guest_file_select
    import stateen_gate_pkg::*;
#(
    parameter int unsigned VGEIN_W = 6,
    parameter int unsigned GEILEN  = 15,
    parameter int unsigned XLEN    = 64
) (
    input  logic               virt_mode,
    input  logic [1:0]         priv,
    input  logic               stateen_present,
    input  logic               h_ifile_bit,
    input  logic [VGEIN_W-1:0] vgein,
    output logic [VGEIN_W-1:0] vgein_eff,
    output logic [XLEN-1:0]    hgeie_mask
);

    logic file_reachable;

    assign file_reachable = virt_mode && (priv != PRIV_M)
                            && (!stateen_present || h_ifile_bit);
    assign vgein_eff      = file_reachable ? vgein : '0;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            hgeie_mask[i] = (i >= 1) && (i <= GEILEN);
        end
    end

endmodule

// File: rtl/csr_stateen_gate.sv
module csr_stateen_gate
    import stateen_gate_pkg::*;
#(
    parameter int unsigned SE_W    = 64,
    parameter int unsigned XLEN    = 64,
    parameter int unsigned VGEIN_W = 6,
    parameter int unsigned GEILEN  = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [11:0]         csr_addr,
    input  logic [1:0]          priv,
    input  logic                virt_mode,
    input  logic [63:0]         mstateen0,
    input  logic [63:0]         hstateen0,
    input  logic                stateen_present,
    input  logic                intr_arch_present,
    input  logic [5:0]          vgein,
    output logic                resp_valid,
    output logic                resp_allow,
    output logic                resp_illegal,
    output logic                resp_virtual,
    output logic [63:0]         mstateen0_wmask,
    output logic [63:0]         hstateen0_wmask,
    output logic [31:0]         stateen0h_wmask,
    output logic [5:0]          vgein_eff,
    output logic [63:0]         hgeie_wmask
);

    localparam int unsigned HALF_W = SE_W / 2;

    gate_grp_e                grp;
    verdict_t                 verdict_d;
    logic [SE_NUM_BITS-1:0]   m_bits;
    logic [SE_NUM_BITS-1:0]   h_bits;
    logic [SE_W-1:0]          full_mask_d;
    logic [HALF_W-1:0]        hi_mask_d;
    logic [VGEIN_W-1:0]       vgein_eff_d;
    logic [XLEN-1:0]          hgeie_mask_d;

    assign m_bits = mstateen0[SE_BIT_ISEL:SE_BIT_IFILE];
    assign h_bits = hstateen0[SE_BIT_ISEL:SE_BIT_IFILE];

    csr_group_decode u_dec (
        .addr (csr_addr),
        .grp  (grp)
    );

    stateen_verdict u_verdict (
        .grp             (grp),
        .priv            (priv),
        .virt_mode       (virt_mode),
        .stateen_present (stateen_present),
        .m_bits          (m_bits),
        .h_bits          (h_bits),
        .verdict         (verdict_d)
    );

    stateen_mask_gen #(.SE_W(SE_W)) u_mask (
        .intr_present (intr_arch_present),
        .full_mask    (full_mask_d),
        .hi_mask      (hi_mask_d)
    );

    guest_file_select #(
        .VGEIN_W (VGEIN_W),
        .GEILEN  (GEILEN),
        .XLEN    (XLEN)
    ) u_gfile (
        .virt_mode       (virt_mode),
        .priv            (priv),
        .stateen_present (stateen_present),
        .h_ifile_bit     (hstateen0[SE_BIT_IFILE]),
        .vgein           (vgein),
        .vgein_eff       (vgein_eff_d),
        .hgeie_mask      (hgeie_mask_d)
    );

    // Single response register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid      <= 1'b0;
            resp_allow      <= 1'b0;
            resp_illegal    <= 1'b0;
            resp_virtual    <= 1'b0;
            mstateen0_wmask <= '0;
            hstateen0_wmask <= '0;
            stateen0h_wmask <= '0;
            vgein_eff       <= '0;
            hgeie_wmask     <= '0;
        end else begin
            resp_valid      <= req_valid;
            resp_allow      <= req_valid && verdict_d.allow;
            resp_illegal    <= req_valid && verdict_d.illegal;
            resp_virtual    <= req_valid && verdict_d.virt_trap;
            mstateen0_wmask <= full_mask_d;
            hstateen0_wmask <= full_mask_d;
            stateen0h_wmask <= hi_mask_d;
            vgein_eff       <= vgein_eff_d;
            hgeie_wmask     <= hgeie_mask_d;
        end
    end

    // R8: one-hot verdict when valid
    a_r8_onehot_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $onehot({resp_allow, resp_illegal, resp_virtual}));

    // R8: silent when not valid
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(resp_allow || resp_illegal || resp_virtual));

    // R5: machine privilege never traps
    a_r5_machine_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv == PRIV_M) |=> resp_allow);

    // R4: absent extension never traps
    a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stateen_present) |=> resp_allow);

    // R7: a virtual trap only comes from a guest request
    a_r7_virt_from_guest: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !virt_mode) |=> !resp_virtual);

    // R10: a non-zero guest file index needs a guest context
    a_r10_vgein_guest: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_mode |=> (vgein_eff == '0));

    // R9: masks follow the architecture-present flag
    a_r9_mask_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_arch_present |=> (mstateen0_wmask == '0 && stateen0h_wmask == '0));

endmodule

// File: tb/tb_csr_stateen_gate.sv
module tb_csr_stateen_gate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [11:0] csr_addr;
    logic [1:0]  priv;
    logic        virt_mode;
    logic [63:0] mstateen0;
    logic [63:0] hstateen0;
    logic        stateen_present;
    logic        intr_arch_present;
    logic [5:0]  vgein;
    logic        resp_valid, resp_allow, resp_illegal, resp_virtual;
    logic [63:0] mstateen0_wmask, hstateen0_wmask, hgeie_wmask;
    logic [31:0] stateen0h_wmask;
    logic [5:0]  vgein_eff;

    always #4 clk = ~clk;  // 125 MHz

    csr_stateen_gate dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .csr_addr          (csr_addr),
        .priv              (priv),
        .virt_mode         (virt_mode),
        .mstateen0         (mstateen0),
        .hstateen0         (hstateen0),
        .stateen_present   (stateen_present),
        .intr_arch_present (intr_arch_present),
        .vgein             (vgein),
        .resp_valid        (resp_valid),
        .resp_allow        (resp_allow),
        .resp_illegal      (resp_illegal),
        .resp_virtual      (resp_virtual),
        .mstateen0_wmask   (mstateen0_wmask),
        .hstateen0_wmask   (hstateen0_wmask),
        .stateen0h_wmask   (stateen0h_wmask),
        .vgein_eff         (vgein_eff),
        .hgeie_wmask       (hgeie_wmask)
    );

    localparam int GEILEN_TB = 15;
    localparam logic [63:0] NOISE = 64'h8123_4567_89AB_CDEF;

    int    errors = 0;
    int    checks = 0;
    bit    finished = 0;

    // Expected values for the request driven last
    logic [3:0]  exp_v;      // {valid, allow, illegal, virtual}
    string       exp_tag;
    logic [63:0] exp_full;
    logic [31:0] exp_hi;
    logic [5:0]  exp_vg;
    logic [63:0] exp_hgeie;
    bit          pending = 0;

    logic [11:0] addrs [22] = '{
        12'h15C, 12'h25C, 12'h600, 12'h607, 12'hE12,
        12'h114, 12'h154, 12'h214, 12'h254, 12'h613, 12'h609,
        12'h655, 12'h646, 12'h647, 12'h656, 12'h657,
        12'h150, 12'h250,
        12'h151, 12'h300, 12'h644, 12'hC00
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_and_drive(input bit v, input logic [11:0] a, input logic [1:0] p,
                                   input bit vm, input logic [2:0] mb, input logic [2:0] hb,
                                   input bit se, input bit ia, input logic [5:0] vg);
        int    b;
        string tg;
        logic [63:0] m, h;
        logic [2:0]  res;
        m = {NOISE[63:61], mb, NOISE[57:0]};
        h = {NOISE[63:61], hb, NOISE[57:0]} ^ 64'h0000_00F0_0000_0F0F;
        b = -1;
        tg = "R4";
        case (a)
            12'h15C, 12'h25C, 12'h600, 12'h607, 12'hE12: begin b = 58; tg = "R1"; end
            12'h114, 12'h154, 12'h214, 12'h254, 12'h613, 12'h609,
            12'h655, 12'h646, 12'h647, 12'h656, 12'h657: begin b = 59; tg = "R2"; end
            12'h150, 12'h250: begin b = 60; tg = "R3"; end
            default: b = -1;
        endcase
        if (!se || b < 0) begin res = 3'b100; tg = "R4"; end
        else if (p == 2'b11) begin res = 3'b100; tg = "R5"; end
        else if (!m[b]) begin res = 3'b010; tg = "R6"; end
        else if (vm && !h[b]) begin res = 3'b001; tg = "R7"; end
        else res = 3'b100;
        if (!v) begin res = 3'b000; tg = "R8"; end
        exp_v     = {v, res};
        exp_tag   = tg;
        exp_full  = ia ? (64'h7 << 58) : 64'h0;
        exp_hi    = ia ? (32'h7 << 26) : 32'h0;
        exp_vg    = (vm && p != 2'b11 && (!se || h[58])) ? vg : 6'd0;
        exp_hgeie = ((64'h1 << GEILEN_TB) - 64'h1) << 1;
        req_valid = v; csr_addr = a; priv = p; virt_mode = vm;
        mstateen0 = m; hstateen0 = h; stateen_present = se;
        intr_arch_present = ia; vgein = vg;
    endtask

    task automatic compare_all();
        check({exp_tag, " verdict"},
              {60'd0, resp_valid, resp_allow, resp_illegal, resp_virtual}, {60'd0, exp_v});
        check("R8 one-hot", {63'd0, resp_valid && !$onehot({resp_allow, resp_illegal, resp_virtual})}, 64'd0);
        check("R9 mstateen0 mask", mstateen0_wmask, exp_full);
        check("R9 hstateen0 mask", hstateen0_wmask, exp_full);
        check("R9 high mask", {32'd0, stateen0h_wmask}, {32'd0, exp_hi});
        check("R10 vgein_eff", {58'd0, vgein_eff}, {58'd0, exp_vg});
        check("R11 hgeie mask", hgeie_wmask, exp_hgeie);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0;
        model_and_drive(1, 12'h15C, 2'b01, 1, 3'b111, 3'b111, 1, 1, 6'd9);
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset verdict", {60'd0, resp_valid, resp_allow, resp_illegal, resp_virtual}, 64'd0);
        check("R12 reset masks", mstateen0_wmask | hstateen0_wmask | {32'd0, stateen0h_wmask}, 64'd0);
        check("R12 reset vgein/hgeie", hgeie_wmask | {58'd0, vgein_eff}, 64'd0);
        rst_n = 1'b1;
        cnt = 0;
        for (int se = 0; se < 2; se++) begin
            for (int ai = 0; ai < 22; ai++) begin
                for (int pi = 0; pi < 3; pi++) begin
                    for (int vm = 0; vm < 2; vm++) begin
                        for (int mb = 0; mb < 8; mb++) begin
                            for (int hb = 0; hb < 8; hb++) begin
                                @(negedge clk);
                                if (pending) compare_all();
                                model_and_drive((cnt % 11) != 0, addrs[ai],
                                                (pi == 2) ? 2'b11 : 2'(pi), vm[0],
                                                3'(mb), 3'(hb), se[0], ((cnt / 3) % 2) == 0,
                                                6'(cnt % 64));
                                pending = 1;
                                cnt++;
                            end
                        end
                    end
                end
            end
        end
        @(negedge clk);
        compare_all();
        finish_run();
    end

endmodule